// File: doc/BRIEF.md
# Loopback Mode Arbiter and Data Router

This block sits at one end of a framed point-to-point link. It decides each frame whether the end runs normally, loops its own transmit data back to its own receive outputs, asks the far end to return its data, or answers such a request from the far end. It then steers a primary and an auxiliary data lane to suit the chosen mode. Line coding, framing detection and the physical layer belong to neighbouring blocks. This block only sees the far-end loopback flag already pulled out of received frames and a single lock/carrier status bit.

A free-running frame timer marks the last cycle of every frame. The mode register and the outbound loopback flag change only on that cycle's clock edge, so a frame is never split between two routings. Every data output is registered, which makes each path one clock of latency.

Top module: `lbk_arbiter_router`

## Requirements
- R1: While `rst` is high all data outputs and `lb_flag_o` are 0, the mode is normal and the frame timer is at position 0.
- R2: In normal mode `line_*_o` equals `tx_*_i` and `rcv_*_o` equals `rx_*_i`, each one clock after the input, for both lanes.
- R3: In local loopback `rcv_*_o` equals `tx_*_i` one clock later on both lanes, and `rx_*_i` has no effect on the receive outputs.
- R4: A local loopback request beats a remote request and a far-end request. While it wins, `lb_flag_o` is cleared at the next frame boundary.
- R5: Local loopback is entered and held whether `link_ok_i` is high or low.
- R6: A remote request that wins arbitration raises `lb_flag_o` at the next frame boundary and holds it every frame. `lb_flag_o` falls at the first frame boundary after the request is dropped.
- R7: While answering a far-end request, `line_*_o` equals `rx_*_i` after one register stage, and `rcv_*_o` still shows `rx_*_i`.
- R8: While this end is answering (the far-end flag is set and lock is high at a boundary), a local remote request is ignored and `lb_flag_o` stays 0.
- R9: Remote loopback in either role is entered only if `link_ok_i` is high at the boundary. If lock is low and no local request is present, the mode at the next boundary is normal.
- R10: The mode changes only on the clock edge that ends a frame. A frame is `FRAME_LEN` cycles long, and the first boundary is the `FRAME_LEN`-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_lb_req_i | input | 1 | Local loopback request |
| rem_lb_req_i | input | 1 | Request to start remote loopback |
| far_lb_flag_i | input | 1 | Loopback request flag decoded from received frames |
| link_ok_i | input | 1 | Lock / carrier detect status |
| tx_pri_i | input | PRI_W | Local primary transmit data |
| tx_aux_i | input | AUX_W | Local auxiliary transmit data |
| rx_pri_i | input | PRI_W | Received primary data |
| rx_aux_i | input | AUX_W | Received auxiliary data |
| line_pri_o | output | PRI_W | Primary data sent toward the line |
| line_aux_o | output | AUX_W | Auxiliary data sent toward the line |
| rcv_pri_o | output | PRI_W | Primary data delivered to the local user |
| rcv_aux_o | output | AUX_W | Auxiliary data delivered to the local user |
| lb_flag_o | output | 1 | Loopback request flag for outgoing frames |

## Verification
The bench raises requests in the middle of frames. A design that switched mode at once would show looped data several cycles too early. It also holds all three requests together: a wrong priority would either retransmit received data or raise the request flag while local loopback should win. The answering phase keeps the local remote request high, so a design without the blocking rule sends a flag in return. Lock is dropped both during local loopback and during a far-end request, which catches a local mode wrongly gated by lock and a remote mode wrongly entered without it.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    LB_NORMAL = 2'd0,
    LB_LOCAL  = 2'd1,
    LB_INIT   = 2'd2,
    LB_ANSWER = 2'd3
  } lb_mode_e;

endpackage

// File: rtl/lbk_frame_timer.sv
module lbk_frame_timer #(
  parameter int FRAME_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  output logic frm_last_o
);
  localparam int CW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frm_last_o = (cnt_q == LAST);

endmodule

// File: rtl/lbk_mode_arbiter.sv
module lbk_mode_arbiter
  import lbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frm_last_i,
  input  logic     loc_req_i,
  input  logic     rem_req_i,
  input  logic     far_req_i,
  input  logic     link_ok_i,
  output lb_mode_e mode_o,
  output logic     flag_o
);
  lb_mode_e mode_q, mode_d;
  logic     flag_q, flag_d;
  logic     answer_win;
  logic     init_win;

  // Fixed priority: local, then answering the far end, then initiating.
  always_comb begin
    answer_win = far_req_i & link_ok_i & ~loc_req_i;
    init_win   = rem_req_i & ~loc_req_i & ~(far_req_i & link_ok_i);
    flag_d     = init_win;
    if (loc_req_i) begin
      mode_d = LB_LOCAL;
    end else if (answer_win) begin
      mode_d = LB_ANSWER;
    end else if (init_win && link_ok_i) begin
      mode_d = LB_INIT;
    end else begin
      mode_d = LB_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LB_NORMAL;
      flag_q <= 1'b0;
    end else if (frm_last_i) begin
      mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/lbk_lane_router.sv
module lbk_lane_router
  import lbk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  lb_mode_e     mode_i,
  input  logic [W-1:0] tx_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] line_o,
  output logic [W-1:0] rcv_o
);
  logic [W-1:0] line_d, rcv_d;

  always_comb begin
    line_d = tx_i;
    rcv_d  = rx_i;
    case (mode_i)
      LB_LOCAL:  rcv_d  = tx_i;
      LB_ANSWER: line_d = rx_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= '0;
      rcv_o  <= '0;
    end else begin
      line_o <= line_d;
      rcv_o  <= rcv_d;
    end
  end

endmodule

// File: rtl/lbk_arbiter_router.sv
module lbk_arbiter_router
  import lbk_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int PRI_W     = 8,
  parameter int AUX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loc_lb_req_i,
  input  logic             rem_lb_req_i,
  input  logic             far_lb_flag_i,
  input  logic             link_ok_i,
  input  logic [PRI_W-1:0] tx_pri_i,
  input  logic [AUX_W-1:0] tx_aux_i,
  input  logic [PRI_W-1:0] rx_pri_i,
  input  logic [AUX_W-1:0] rx_aux_i,
  output logic [PRI_W-1:0] line_pri_o,
  output logic [AUX_W-1:0] line_aux_o,
  output logic [PRI_W-1:0] rcv_pri_o,
  output logic [AUX_W-1:0] rcv_aux_o,
  output logic             lb_flag_o
);
  logic     frm_last;
  lb_mode_e mode_q;

  lbk_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .frm_last_o (frm_last)
  );

  lbk_mode_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .frm_last_i (frm_last),
    .loc_req_i  (loc_lb_req_i),
    .rem_req_i  (rem_lb_req_i),
    .far_req_i  (far_lb_flag_i),
    .link_ok_i  (link_ok_i),
    .mode_o     (mode_q),
    .flag_o     (lb_flag_o)
  );

  lbk_lane_router #(.W(PRI_W)) u_pri (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_q),
    .tx_i   (tx_pri_i),
    .rx_i   (rx_pri_i),
    .line_o (line_pri_o),
    .rcv_o  (rcv_pri_o)
  );

  lbk_lane_router #(.W(AUX_W)) u_aux (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_q),
    .tx_i   (tx_aux_i),
    .rx_i   (rx_aux_i),
    .line_o (line_aux_o),
    .rcv_o  (rcv_aux_o)
  );

endmodule

// File: rtl/lbk_checker.sv
module lbk_checker
  import lbk_pkg::*;
#(
  parameter int PRI_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_last,
  input lb_mode_e         mode_q,
  input logic             loc_lb_req_i,
  input logic             rem_lb_req_i,
  input logic             far_lb_flag_i,
  input logic             link_ok_i,
  input logic [PRI_W-1:0] tx_pri_i,
  input logic [PRI_W-1:0] rx_pri_i,
  input logic [PRI_W-1:0] line_pri_o,
  input logic [PRI_W-1:0] rcv_pri_o,
  input logic             lb_flag_o
);
  AST_MODE_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !frm_last |=> $stable(mode_q)); // R10

  AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (frm_last && loc_lb_req_i) |=> (mode_q == LB_LOCAL && !lb_flag_o)); // R4

  AST_LOCAL_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_LOCAL) |=> (rcv_pri_o == $past(tx_pri_i))); // R3

  AST_ANSWER_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_ANSWER) |=> (line_pri_o == $past(rx_pri_i) && rcv_pri_o == $past(rx_pri_i))); // R7

  AST_ANSWER_BLOCKS_INIT: assert property (@(posedge clk) disable iff (rst)
    (frm_last && far_lb_flag_i && link_ok_i) |=> !lb_flag_o); // R8

  AST_NO_LOCK_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (frm_last && !loc_lb_req_i && !link_ok_i) |=> (mode_q == LB_NORMAL)); // R9

  AST_FLAG_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (frm_last && !rem_lb_req_i) |=> !lb_flag_o); // R6

endmodule

bind lbk_arbiter_router lbk_checker #(.PRI_W(PRI_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frm_last      (frm_last),
  .mode_q        (mode_q),
  .loc_lb_req_i  (loc_lb_req_i),
  .rem_lb_req_i  (rem_lb_req_i),
  .far_lb_flag_i (far_lb_flag_i),
  .link_ok_i     (link_ok_i),
  .tx_pri_i      (tx_pri_i),
  .rx_pri_i      (rx_pri_i),
  .line_pri_o    (line_pri_o),
  .rcv_pri_o     (rcv_pri_o),
  .lb_flag_o     (lb_flag_o)
);

// File: tb/tb_lbk_arbiter_router.sv
`timescale 1ns/1ps
module tb_lbk_arbiter_router;
  localparam int FL = 8;
  localparam int PW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc = 0, rem = 0, far = 0, lock = 0;
  logic [PW-1:0] txp = '0, rxp = '0;
  logic [AW-1:0] txa = '0, rxa = '0;
  logic [PW-1:0] linep, rcvp;
  logic [AW-1:0] linea, rcva;
  logic flag;

  int total = 0, bad = 0;
  string ph_tag = "R1";
  bit armed = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  int m_mode = 0; // 0 normal, 1 local, 2 initiate, 3 answer
  logic m_flag = 0;
  logic [PW-1:0] e_linep = '0, e_rcvp = '0;
  logic [AW-1:0] e_linea = '0, e_rcva = '0;
  logic [PW-1:0] last_rxp = '0;

  always #2.5 clk = ~clk;

  lbk_arbiter_router #(.FRAME_LEN(FL), .PRI_W(PW), .AUX_W(AW)) dut (
    .clk(clk), .rst(rst),
    .loc_lb_req_i(loc), .rem_lb_req_i(rem), .far_lb_flag_i(far), .link_ok_i(lock),
    .tx_pri_i(txp), .tx_aux_i(txa), .rx_pri_i(rxp), .rx_aux_i(rxa),
    .line_pri_o(linep), .line_aux_o(linea), .rcv_pri_o(rcvp), .rcv_aux_o(rcva),
    .lb_flag_o(flag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model, evaluated with the inputs held before the edge
  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_mode = 0; m_flag = 0;
      e_linep = '0; e_rcvp = '0; e_linea = '0; e_rcva = '0;
    end else begin
      e_linep = (m_mode == 3) ? rxp : txp;
      e_linea = (m_mode == 3) ? rxa : txa;
      e_rcvp  = (m_mode == 1) ? txp : rxp;
      e_rcva  = (m_mode == 1) ? txa : rxa;
      if (m_cnt == FL - 1) begin
        m_flag = rem && !loc && !(far && lock);
        if (loc) m_mode = 1;
        else if (far && lock) m_mode = 3;
        else if (rem && lock) m_mode = 2;
        else m_mode = 0;
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  function automatic string mode_tag();
    if (ph_tag != "") return ph_tag;
    case (m_mode)
      1: return "R3";
      2: return "R6";
      3: return "R7";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin
    if (armed && !done) begin
      check(mode_tag(), 32'(linep), 32'(e_linep), "line_pri");
      check(mode_tag(), 32'(linea), 32'(e_linea), "line_aux");
      check(mode_tag(), 32'(rcvp),  32'(e_rcvp),  "rcv_pri");
      check(mode_tag(), 32'(rcva),  32'(e_rcva),  "rcv_aux");
      check((ph_tag != "") ? ph_tag : "R6", 32'(flag), 32'(m_flag), "lb_flag");
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      last_rxp = rxp;
      txp = PW'($urandom); rxp = PW'($urandom);
      txa = AW'($urandom); rxa = AW'($urandom);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ph_tag = "R1";
    run(4);
    check("R1", 32'(rcvp), 0, "rcv_pri in reset");
    check("R1", 32'(linep), 0, "line_pri in reset");
    check("R1", 32'(flag), 0, "flag in reset");
    @(negedge clk); rst = 0;
    ph_tag = "";
    lock = 1;
    run(3 * FL);                           // R2 normal
    // R10: request mid-frame must wait for the boundary
    while (m_cnt != 1) run(1);
    loc = 1;
    run(2);
    check("R10", 32'(rcvp), 32'(last_rxp), "rcv_pri before boundary");
    ph_tag = "R3"; run(3 * FL);            // R3 local
    lock = 0; ph_tag = "R5"; run(3 * FL);  // R5 local without lock
    lock = 1; rem = 1; far = 1; ph_tag = "R4"; run(3 * FL); // R4 priority
    loc = 0; far = 0; ph_tag = "R6"; run(3 * FL);           // R6 initiate
    rem = 0; run(2 * FL);                                   // R6 release
    far = 1; ph_tag = "R7"; run(3 * FL);                    // R7 answer
    rem = 1; ph_tag = "R8"; run(3 * FL);                    // R8 blocked
    lock = 0; ph_tag = "R9"; run(3 * FL);                   // R9 no lock
    far = 0; rem = 0; lock = 1; ph_tag = "R2"; run(2 * FL);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule